// File: doc/BRIEF.md
# Cascadable Eight-Line Vectored Interrupt Controller

This block gathers up to eight interrupt request lines and turns the most urgent one into a single request towards the processor, along with an 8-bit vector. A host reaches the block through a byte-wide port with two addresses. The low address takes command bytes, and their control bits pick one of three kinds: a start-of-setup word, a status-view selector, or an end-of-service word. The high address first takes the remaining setup words. After that it works as the mask register. The second setup word sets the vector base.

Each input line is edge-sensitive. A 0-to-1 transition latches a pending bit, and that bit stays until the interrupt is delivered. Delivery is a valid/ready handshake on the vector output. `vec_valid` is high while any unmasked pending bit exists, and `vec_data` carries the base plus the index of the lowest-numbered such bit. When `vec_ready` is also high at a clock edge, that bit moves from pending to in-service. While `vec_ready` stays low, the block holds the request and keeps nothing else back. If a lower-numbered source becomes pending in the meantime, the offered vector may change before the transfer.

Two copies form a cascade: the output request of one copy drives one request line of the other.

Top module: `vic8_ctrl`

## Requirements
- R1: After reset the mask is 0xFF (all lines masked), `vec_valid` is 0, and a low-address read returns 0xFF.
- R2: A low-address write with bit 4 set starts setup. The next three high-address writes are setup words two to four and leave the mask unchanged. The high-address write after those loads the mask.
- R3: `vec_data` equals setup word two plus the index of the winning line.
- R4: Outside setup, a high-address write loads the mask (bit i = 1 masks line i), and a high-address read returns it.
- R5: A low-address write with bit 4 = 0 and bit 3 = 1 is a view selector. Its bits [1:0] = 11 make a low-address read return the in-service bits, 10 make it return the pending bits, and any other value makes it return 0xFF.
- R6: A pending bit is set only by a 0-to-1 transition of its line. A line held high does not request again after delivery.
- R7: `vec_valid` is high exactly when some pending bit is unmasked. A masked pending bit is kept and is delivered once it is unmasked.
- R8: When several unmasked bits are pending, the lowest-numbered one wins.
- R9: At a clock edge with `vec_valid` and `vec_ready` both high, the winner's pending bit clears and its in-service bit sets. From the next cycle, the outputs reflect the remaining requests.
- R10: While `vec_ready` is low and the mask is not written, `vec_valid` stays high and no pending bit is lost.
- R11: A low-address write with bits 4 and 3 clear and bits [7:5] = 001 clears the lowest-numbered in-service bit. With bits [7:5] = 011, it clears the in-service bit numbered by bits [2:0].
- R12: If a line rises in the same cycle its bit is delivered, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 8 | Interrupt request lines, edge-sensitive |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 1 | 0 = command/status address, 1 = setup/mask address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the current `host_addr` |
| vec_valid | output | 1 | Interrupt request to the processor |
| vec_ready | input | 1 | Processor accepts the offered vector |
| vec_data | output | 8 | Vector: base plus winning index |

## Verification
The bench builds the block with its defaults: eight lines, an 8-bit data path and a four-word setup sequence. With these values every line index fits the 3-bit level field of the specific end-of-service word, and the vector base of 0x40 plus any index stays inside one byte. Because the sequence has four words, the bench can check that exactly three high-address writes are taken as setup before the mask responds. The eight lines also let it place masked, simultaneous and coinciding edges on distinct indices, which exercises priority, back-pressure and the case where a new edge arrives during a delivery.

// File: rtl/vic8_pkg.sv
package vic8_pkg;
  localparam int SETUP_BIT = 4;
  localparam int VIEW_BIT  = 3;

  typedef enum logic [1:0] {
    LO_NOP   = 2'd0,
    LO_SETUP = 2'd1,
    LO_VIEW  = 2'd2,
    LO_EOS   = 2'd3
  } lo_kind_e;

  localparam logic [1:0] VIEW_INSERV  = 2'b11;
  localparam logic [1:0] VIEW_PENDING = 2'b10;

  localparam logic [2:0] EOS_LOWEST = 3'b001;
  localparam logic [2:0] EOS_LEVEL  = 3'b011;

  function automatic lo_kind_e classify(input logic [7:0] b);
    if (b[SETUP_BIT])                                 return LO_SETUP;
    else if (b[VIEW_BIT])                             return LO_VIEW;
    else if (b[7:5] == EOS_LOWEST || b[7:5] == EOS_LEVEL) return LO_EOS;
    else                                              return LO_NOP;
  endfunction
endpackage

// File: rtl/vic8_host.sv
module vic8_host
  import vic8_pkg::*;
#(
  parameter int N_IN     = 8,
  parameter int DW       = 8,
  parameter int INIT_LEN = 4,
  localparam int IDX_W   = $clog2(N_IN),
  localparam int CW      = $clog2(INIT_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [DW-1:0]    wdata,
  output logic [N_IN-1:0]  mask,
  output logic [DW-1:0]    base,
  output logic [1:0]       view_sel,
  output logic             eos_lowest,
  output logic             eos_level,
  output logic [IDX_W-1:0] eos_idx
);
  logic [CW-1:0] step;
  lo_kind_e      kind;
  logic          lo_wr, hi_wr, in_setup;

  assign lo_wr    = wr && !addr;
  assign hi_wr    = wr && addr;
  assign in_setup = (step != '0);
  assign kind     = classify(wdata[7:0]);

  assign eos_lowest = lo_wr && kind == LO_EOS && wdata[7:5] == EOS_LOWEST;
  assign eos_level  = lo_wr && kind == LO_EOS && wdata[7:5] == EOS_LEVEL;
  assign eos_idx    = wdata[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= '1;
      base     <= '0;
      view_sel <= 2'b00;
      step     <= '0;
    end else begin
      if (lo_wr) begin
        if (kind == LO_SETUP) step <= CW'(1);
        else if (kind == LO_VIEW) view_sel <= wdata[1:0];
      end
      if (hi_wr) begin
        if (in_setup) begin
          if (step == CW'(1)) base <= wdata;
          step <= (step == CW'(INIT_LEN - 1)) ? '0 : step + CW'(1);
        end else begin
          mask <= wdata[N_IN-1:0];
        end
      end
    end
  end

  // R1: mask comes out of reset fully set
  assert_mask_reset_R1: assert property (@(posedge clk) !rst_n |=> (mask == '1));
  // R2: setup words never disturb the mask
  assert_setup_keeps_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_setup && hi_wr) |=> $stable(mask));
  // R2: the sequencer stays inside its word count
  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step < CW'(INIT_LEN));
endmodule

// File: rtl/vic8_reqs.sv
module vic8_reqs #(
  parameter int N_IN   = 8,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  lines,
  input  logic             take,
  input  logic [IDX_W-1:0] take_idx,
  input  logic             eos_lowest,
  input  logic             eos_level,
  input  logic [IDX_W-1:0] eos_idx,
  output logic [N_IN-1:0]  pending,
  output logic [N_IN-1:0]  inserv
);
  logic [N_IN-1:0] prev, rise, take_oh, lowest_is, clr;

  assign rise      = lines & ~prev;
  assign take_oh   = take ? (N_IN'(1) << take_idx) : '0;
  assign lowest_is = inserv & (~inserv + N_IN'(1));
  assign clr       = (eos_lowest ? lowest_is : '0) |
                     (eos_level ? (N_IN'(1) << eos_idx) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '0;
      pending <= '0;
      inserv  <= '0;
    end else begin
      prev    <= lines;
      pending <= (pending & ~take_oh) | rise;
      inserv  <= (inserv & ~clr) | take_oh;
    end
  end

  // R9: a delivered bit leaves pending and enters in-service
  assert_take_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rise[take_idx]) |=> (!pending[$past(take_idx)] && inserv[$past(take_idx)]));
  // R6, R12: every rising edge leaves its bit pending
  assert_edge_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((pending & $past(rise)) == $past(rise)));
endmodule

// File: rtl/vic8_pick.sv
module vic8_pick #(
  parameter int N_IN   = 8,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]  req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  logic [N_IN:0] seen;

  assign seen[0] = 1'b0;
  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_chain
      assign seen[i+1] = seen[i] | req[i];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (req[i] && !seen[i]) idx = IDX_W'(i);
    end
  end

  assign found = seen[N_IN];
endmodule

// File: rtl/vic8_ctrl.sv
module vic8_ctrl
  import vic8_pkg::*;
#(
  parameter int N_IN     = 8,
  parameter int DW       = 8,
  parameter int INIT_LEN = 4,
  localparam int IDX_W   = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] irq_lines,
  input  logic            host_wr,
  input  logic            host_addr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  output logic            vec_valid,
  input  logic            vec_ready,
  output logic [DW-1:0]   vec_data
);
  logic [N_IN-1:0]  mask, pending, inserv, live;
  logic [DW-1:0]    base;
  logic [1:0]       view_sel;
  logic             eos_lowest, eos_level, take;
  logic [IDX_W-1:0] eos_idx, win_idx;

  vic8_host #(.N_IN(N_IN), .DW(DW), .INIT_LEN(INIT_LEN)) u_host (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .mask(mask), .base(base), .view_sel(view_sel),
    .eos_lowest(eos_lowest), .eos_level(eos_level), .eos_idx(eos_idx)
  );

  vic8_reqs #(.N_IN(N_IN)) u_reqs (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines),
    .take(take), .take_idx(win_idx),
    .eos_lowest(eos_lowest), .eos_level(eos_level), .eos_idx(eos_idx),
    .pending(pending), .inserv(inserv)
  );

  assign live = pending & ~mask;

  vic8_pick #(.N_IN(N_IN)) u_pick (.req(live), .found(vec_valid), .idx(win_idx));

  assign take     = vec_valid && vec_ready;
  assign vec_data = base + DW'(win_idx);

  always_comb begin
    if (host_addr)                    host_rdata = DW'(mask);
    else if (view_sel == VIEW_INSERV)  host_rdata = DW'(inserv);
    else if (view_sel == VIEW_PENDING) host_rdata = DW'(pending);
    else                               host_rdata = '1;
  end

  // R7: the request follows the unmasked pending set
  assert_valid_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid == (|(pending & ~mask)));
  // R8: the offered index is pending and has no lower-numbered rival
  assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (live[win_idx] && ((live & ~({N_IN{1'b1}} << win_idx)) == '0)));
  // R10: without acceptance or a mask write, the request is held
  assert_hold_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready && !(host_wr && host_addr)) |=> vec_valid);
endmodule

// File: tb/sim_vic8_ctrl.sv
`timescale 1ns/1ps
module sim_vic8_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_lines = '0;
  logic       host_wr = 1'b0;
  logic       host_addr = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       vec_valid;
  logic       vec_ready = 1'b0;
  logic [7:0] vec_data;

  always #2.5 clk = ~clk;

  vic8_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data)
  );

  typedef struct {
    int         kind;   // 0 read data, 1 request, 2 vector
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 0;

  // monitor: compare queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sbq.pop_front();
        case (it.kind)
          0: act = host_rdata;
          1: act = {7'b0, vec_valid};
          default: act = vec_data;
        endcase
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    host_wr = 1'b0; host_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic expect_req(input logic v, input logic [7:0] d, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.kind = 1; it.exp = {7'b0, v}; it.tag = tag;
    sbq.push_back(it);
    if (v) begin
      it.kind = 2; it.exp = d;
      sbq.push_back(it);
    end
  endtask

  task automatic set_lines(input logic [7:0] l);
    @(posedge clk); #1;
    irq_lines = l;
  endtask

  task automatic accept();
    @(posedge clk); #1;
    vec_ready = 1'b1;
    @(posedge clk); #1;
    vec_ready = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(1'b1, 8'hFF, "R1 mask after reset");
    rd(1'b0, 8'hFF, "R1 status view after reset");
    expect_req(1'b0, 8'h00, "R1 no request after reset");

    wr(1'b0, 8'h11);
    wr(1'b1, 8'h40);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h00);
    rd(1'b1, 8'hFF, "R2 setup words leave mask");
    wr(1'b1, 8'hF0);
    rd(1'b1, 8'hF0, "R4 mask loads after setup");

    set_lines(8'h20);
    expect_req(1'b0, 8'h00, "R7 masked line gives no request");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h20, "R5 pending view shows masked bit");

    set_lines(8'h2C);
    expect_req(1'b1, 8'h42, "R8 R3 lowest of lines 2 and 3");
    accept();
    expect_req(1'b1, 8'h43, "R9 next request after accept");
    rd(1'b0, 8'h28, "R9 delivered bit left pending");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h04, "R9 in-service view");

    repeat (3) @(posedge clk);
    expect_req(1'b1, 8'h43, "R10 request held without ready");
    accept();
    expect_req(1'b0, 8'h00, "R7 only masked bit remains");
    rd(1'b0, 8'h0C, "R9 two bits in service");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h20, "R6 held lines do not request again");

    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R11 lowest in-service cleared");
    wr(1'b0, 8'h63);
    rd(1'b0, 8'h00, "R11 numbered in-service cleared");

    wr(1'b1, 8'h00);
    expect_req(1'b1, 8'h45, "R7 unmasked bit delivered");
    accept();
    expect_req(1'b0, 8'h00, "R9 queue empty");

    set_lines(8'h00);
    set_lines(8'h01);
    expect_req(1'b1, 8'h40, "R3 vector for line 0");
    set_lines(8'h00);
    @(posedge clk); #1;
    irq_lines = 8'h01; vec_ready = 1'b1;
    @(posedge clk); #1;
    vec_ready = 1'b0;
    expect_req(1'b1, 8'h40, "R12 edge during delivery stays pending");
    accept();
    expect_req(1'b0, 8'h00, "R9 second delivery drains line 0");

    wr(1'b0, 8'h08);
    rd(1'b0, 8'hFF, "R5 view code 00 reads all ones");

    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule